// File: doc/BRIEF.md
# Supply-Monitor Reset Sequencer

This block generates the active-low reset for a small microcontroller core. It watches a digital "supply is above the reset threshold" level produced by an analog comparator, together with a monitor-enable pin and three other reset requests: the external reset pin, the watchdog and a software request. While the supply is low, the core is held in reset. Once the supply has been good for a fixed timeout (100 ms by default, converted to clock ticks from the clock frequency parameter), the core is released. A power failure during operation puts the core straight back into reset, and the core leaves that reset through the same timeout.

The block keeps a reset-cause register that firmware reads after restart. A monitor-caused reset leaves only the power-on bit set. Any other cause sets its own bit and clears the power-on bit. Writing the register controls whether the supply monitor may trigger resets at all: bit 1 of the written value must be 1 to keep the monitor active. Every reset cause restarts the core at the same address, which the block exports as a constant. The clock is assumed to come from an always-on oscillator. `rst_ni` is the cold-start clear of the block's own flops.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, `rst_no` is 0 and `src_flags_o` is 0x00.
- R2: With the monitor active, `rst_no` stays 0 while the supply is low. After `supply_ok_i` rises, `rst_no` becomes 1 on the (HOLD_TICKS+2)-th rising clock edge, counting the 2 synchronizer stages, where HOLD_TICKS = CLK_HZ/1000*HOLD_MS.
- R3: In normal operation with the monitor active, a drop of `supply_ok_i` drives `rst_no` to 0 on the third rising edge after the drop. Exit from that reset follows R2.
- R4: A supply drop seen during the timeout clears the count. Release then happens HOLD_TICKS+2 edges after the last rise.
- R5: On exit from a monitor-caused reset, `src_flags_o` equals 0x02: bit 1 (power-on) is 1 and every other bit is 0.
- R6: A pin, watchdog or software request sampled at a rising edge while `rst_no` is 1 drives `rst_no` to 0 from that edge for exactly PULSE_CYCLES cycles. From that edge on, `src_flags_o` holds bit 0 for a pin request, bit 2 for a watchdog request and bit 3 for a software request. Bit 1 is cleared, as is every bit whose source was not requested.
- R7: A request that arrives during a reset pulse ORs its flag into `src_flags_o` and restarts the pulse, so the pulse ends PULSE_CYCLES edges after the last request.
- R8: While `mon_en_i` is 0, a supply drop does not assert reset and leaves `src_flags_o` unchanged.
- R9: A register write (`reg_wr_i` while `rst_no` is 1) with `reg_wdata_i[1]`=0 stops the monitor from triggering resets. A later write with bit 1 = 1 makes it active again. A write never changes `src_flags_o`.
- R10: `restart_vec_o` is always 0x0000.
- R11: A supply failure overrides a reset pulse in progress or a request in the same cycle. The reset then ends as a monitor reset, with `src_flags_o` = 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Cold-start clear of the block's flops, active low |
| supply_ok_i | input | 1 | Comparator level, 1 = supply above the reset threshold (asynchronous) |
| mon_en_i | input | 1 | Monitor enable pin; the monitor acts only when it is 1 |
| pin_req_i | input | 1 | External pin reset request |
| wdt_req_i | input | 1 | Watchdog reset request |
| sw_req_i | input | 1 | Software reset request |
| reg_wr_i | input | 1 | Write strobe for the reset-cause register |
| reg_wdata_i | input | 8 | Write data; bit 1 selects the monitor as a reset source |
| rst_no | output | 1 | Core reset, active low |
| src_flags_o | output | 8 | Reset-cause flags |
| restart_vec_o | output | 16 | Restart address, constant 0 |

## Verification
The bench times release to the exact edge after a supply rise. A design with one synchronizer stage too few or too many, or an off-by-one in the timeout, releases one cycle early or late. A supply glitch inside the timeout shows whether the count is restarted: a design that only pauses it releases hundreds of cycles early. Random mixes of pin, watchdog and software requests check the pulse width and the flag encoding, and a second request inside a pulse shows whether flags are merged and the pulse restarted. The bench drops the supply with the monitor pin low and again after a firmware write of bit 1 = 0: a design that ignores either gate resets, and one that then fails to re-arm on a bit 1 = 1 write never resets.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        ST_MONHOLD = 2'd0,
        ST_PULSE   = 2'd1,
        ST_RUN     = 2'd2
    } seq_state_e;

    // bit positions of the cause register (bit 1 is also the monitor select on writes)
    localparam int FLG_PIN = 0;
    localparam int FLG_POR = 1;
    localparam int FLG_WDT = 2;
    localparam int FLG_SW  = 3;

    typedef struct packed {
        logic sw;
        logic wdt;
        logic pin;
    } req_t;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
#(
    parameter int HOLD_TICKS   = 10_000_000,
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sup_ok_i,
    input  logic mon_act_i,
    input  req_t req_i,
    output logic rst_no,
    output logic run_o,
    output logic por_load_o,
    output logic ext_load_o,
    output logic ext_merge_o
);
    localparam int MAXC = (HOLD_TICKS > PULSE_CYCLES) ? HOLD_TICKS : PULSE_CYCLES;
    localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_CYCLES - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic          rst_n;
    } fsm_t;

    fsm_t f_d, f_q;
    logic mon_fail;
    logic any_req;

    assign mon_fail = mon_act_i && !sup_ok_i;
    assign any_req  = req_i.pin || req_i.wdt || req_i.sw;

    always_comb begin
        f_d         = f_q;
        por_load_o  = 1'b0;
        ext_load_o  = 1'b0;
        ext_merge_o = 1'b0;
        unique case (f_q.st)
            ST_MONHOLD: begin
                if (mon_fail) begin
                    f_d.cnt = '0;
                end else if (f_q.cnt == HOLD_LAST) begin
                    f_d.st     = ST_RUN;
                    f_d.cnt    = '0;
                    por_load_o = 1'b1;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_PULSE: begin
                if (mon_fail) begin
                    f_d.st  = ST_MONHOLD;
                    f_d.cnt = '0;
                end else if (any_req) begin
                    f_d.cnt     = '0;
                    ext_merge_o = 1'b1;
                end else if (f_q.cnt == PULSE_LAST) begin
                    f_d.st  = ST_RUN;
                    f_d.cnt = '0;
                end else begin
                    f_d.cnt = f_q.cnt + 1'b1;
                end
            end
            ST_RUN: begin
                if (mon_fail) begin
                    f_d.st  = ST_MONHOLD;
                    f_d.cnt = '0;
                end else if (any_req) begin
                    f_d.st     = ST_PULSE;
                    f_d.cnt    = '0;
                    ext_load_o = 1'b1;
                end
            end
            default: begin
                f_d.st  = ST_MONHOLD;
                f_d.cnt = '0;
            end
        endcase
        f_d.rst_n = (f_d.st == ST_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q.st    <= ST_MONHOLD;
            f_q.cnt   <= '0;
            f_q.rst_n <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign rst_no = f_q.rst_n;
    assign run_o  = f_q.rst_n;

    // R3
    power_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_q.st == ST_RUN && mon_act_i && !sup_ok_i) |=> (!rst_no && f_q.st == ST_MONHOLD));

    // R4
    hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_q.st == ST_MONHOLD && mon_act_i && !sup_ok_i) |=> (f_q.cnt == '0 && !rst_no));

    // R6
    pulse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_q.st == ST_PULSE && f_q.cnt != PULSE_LAST) |=> !rst_no);

    // R8
    mon_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_q.st == ST_RUN && !mon_act_i && !any_req) |=> rst_no);
endmodule

// File: rtl/rsq_flags.sv
module rsq_flags
    import rsq_pkg::*;
#(
    parameter int FLAG_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              por_load_i,
    input  logic              ext_load_i,
    input  logic              ext_merge_i,
    input  req_t              req_i,
    input  logic              wr_en_i,
    input  logic [FLAG_W-1:0] wdata_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              mon_sel_o
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              mon_sel;
    } flg_t;

    flg_t r_d, r_q;
    logic [FLAG_W-1:0] req_bits;
    logic [FLAG_W-1:0] por_bits;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        req_bits          = '0;
        req_bits[FLG_PIN] = req_i.pin;
        req_bits[FLG_WDT] = req_i.wdt;
        req_bits[FLG_SW]  = req_i.sw;
        por_bits          = '0;
        por_bits[FLG_POR] = 1'b1;
    end

    always_comb begin
        r_d = r_q;
        if (por_load_i) begin
            r_d.flags = por_bits;
        end else if (ext_load_i) begin
            r_d.flags = req_bits;
        end else if (ext_merge_i) begin
            r_d.flags = (r_q.flags | req_bits) & ~por_bits;
        end
        if (wr_en_i && run_i) begin
            r_d.mon_sel = wdata_i[FLG_POR];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.flags   <= '0;
            r_q.mon_sel <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign flags_o   = r_q.flags;
    assign mon_sel_o = r_q.mon_sel;

    // R5
    por_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        por_load_i |=> (flags_o == por_bits));

    // R6
    ext_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_load_i || ext_merge_i) |=> !flags_o[FLG_POR]);

    // R9
    sel_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && run_i && !wdata_i[FLG_POR]) |=> !mon_sel_o);

    // R9
    wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !por_load_i && !ext_load_i && !ext_merge_i) |=> $stable(flags_o));
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import rsq_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int HOLD_MS      = 100,
    parameter int PULSE_CYCLES = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int FLAG_W       = 8,
    parameter int VEC_W        = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              supply_ok_i,
    input  logic              mon_en_i,
    input  logic              pin_req_i,
    input  logic              wdt_req_i,
    input  logic              sw_req_i,
    input  logic              reg_wr_i,
    input  logic [FLAG_W-1:0] reg_wdata_i,
    output logic              rst_no,
    output logic [FLAG_W-1:0] src_flags_o,
    output logic [VEC_W-1:0]  restart_vec_o
);
    localparam int HOLD_TICKS = (CLK_HZ / 1000) * HOLD_MS;

    logic sup_sync;
    logic mon_sel;
    logic mon_act;
    logic run;
    logic por_load, ext_load, ext_merge;
    req_t req;

    assign req.pin = pin_req_i;
    assign req.wdt = wdt_req_i;
    assign req.sw  = sw_req_i;
    assign mon_act = mon_en_i && mon_sel;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (supply_ok_i),
        .q_o   (sup_sync)
    );

    rsq_fsm #(.HOLD_TICKS(HOLD_TICKS), .PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sup_ok_i   (sup_sync),
        .mon_act_i  (mon_act),
        .req_i      (req),
        .rst_no     (rst_no),
        .run_o      (run),
        .por_load_o (por_load),
        .ext_load_o (ext_load),
        .ext_merge_o(ext_merge)
    );

    rsq_flags #(.FLAG_W(FLAG_W)) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run),
        .por_load_i (por_load),
        .ext_load_i (ext_load),
        .ext_merge_i(ext_merge),
        .req_i      (req),
        .wr_en_i    (reg_wr_i),
        .wdata_i    (reg_wdata_i),
        .flags_o    (src_flags_o),
        .mon_sel_o  (mon_sel)
    );

    assign restart_vec_o = '0;

    // R11
    fail_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mon_act && !sup_sync) |=> !rst_no);

    // R8
    disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_no && !mon_en_i && !pin_req_i && !wdt_req_i && !sw_req_i) |=> rst_no);
endmodule

// File: tb/supply_reset_seq_test.sv
`timescale 1ns/1ps
module supply_reset_seq_test;
    localparam int CLK_HZ = 20000;
    localparam int HOLD_MS = 100;
    localparam int P = 16;
    localparam int H = (CLK_HZ / 1000) * HOLD_MS;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic supply_ok = 1'b0;
    logic mon_en = 1'b1;
    logic pin_req = 1'b0, wdt_req = 1'b0, sw_req = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic rst_n;
    logic [7:0] flags;
    logic [15:0] vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    supply_reset_seq #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS), .PULSE_CYCLES(P)) uut (
        .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .mon_en_i(mon_en),
        .pin_req_i(pin_req), .wdt_req_i(wdt_req), .sw_req_i(sw_req),
        .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .rst_no(rst_n), .src_flags_o(flags), .restart_vec_o(vec)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // bits = {sw, wdt, pin}; pin->bit0, wdt->bit2, sw->bit3
    function automatic logic [7:0] exp_ext(input logic [2:0] bits);
        return {4'b0000, bits[2], bits[1], 1'b0, bits[0]};
    endfunction

    task automatic ext_pulse(input logic [2:0] bits, input string req);
        {sw_req, wdt_req, pin_req} = bits;
        tick(1);
        {sw_req, wdt_req, pin_req} = 3'b000;
        check(req, {31'd0, rst_n}, 32'd0);
        check(req, {24'd0, flags}, {24'd0, exp_ext(bits)});
        tick(P - 1);
        check(req, {31'd0, rst_n}, 32'd0);
        tick(1);
        check(req, {31'd0, rst_n}, 32'd1);
        check(req, {24'd0, flags}, {24'd0, exp_ext(bits)});
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wdata = d;
        reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rise_and_release(input string req);
        supply_ok = 1'b1;
        tick(H + 1);
        check(req, {31'd0, rst_n}, 32'd0);
        tick(1);
        check(req, {31'd0, rst_n}, 32'd1);
        check("R5", {24'd0, flags}, 32'h02);
    endtask

    initial begin
        logic [7:0] saved;
        void'($urandom(32'd2024));
        tick(3);
        check("R1", {31'd0, rst_n}, 32'd0);
        check("R1", {24'd0, flags}, 32'h00);
        rst_ni = 1'b1;
        tick(5);
        check("R1", {31'd0, rst_n}, 32'd0);
        check("R1", {24'd0, flags}, 32'h00);
        check("R10", {16'd0, vec}, 32'd0);

        tick(20);
        check("R2", {31'd0, rst_n}, 32'd0);
        rise_and_release("R2");

        // power fail
        tick(7);
        supply_ok = 1'b0;
        tick(2);
        check("R3", {31'd0, rst_n}, 32'd1);
        tick(1);
        check("R3", {31'd0, rst_n}, 32'd0);
        tick(10);
        // glitch during timeout
        supply_ok = 1'b1;
        tick(500);
        check("R4", {31'd0, rst_n}, 32'd0);
        supply_ok = 1'b0;
        tick(3);
        rise_and_release("R4");
        check("R10", {16'd0, vec}, 32'd0);

        // directed external sources
        tick(3);
        ext_pulse(3'b001, "R6");
        tick(2);
        ext_pulse(3'b010, "R6");
        tick(2);
        ext_pulse(3'b100, "R6");
        tick(2);
        ext_pulse(3'b111, "R6");

        // merge during pulse
        tick(3);
        pin_req = 1'b1;
        tick(1);
        pin_req = 1'b0;
        tick(4);
        wdt_req = 1'b1;
        tick(1);
        wdt_req = 1'b0;
        tick(P - 1);
        check("R7", {31'd0, rst_n}, 32'd0);
        tick(1);
        check("R7", {31'd0, rst_n}, 32'd1);
        check("R7", {24'd0, flags}, 32'h05);

        // random mix of sources and harmless writes
        for (int i = 0; i < 40; i++) begin
            logic [2:0] b;
            int gap;
            b = 3'($urandom_range(1, 7));
            gap = $urandom_range(1, 6);
            tick(gap);
            saved = flags;
            wr(8'($urandom) | 8'h02);
            check("R9", {24'd0, flags}, {24'd0, saved});
            ext_pulse(b, "R6");
        end

        // monitor pin low: drop ignored
        saved = flags;
        mon_en = 1'b0;
        tick(1);
        supply_ok = 1'b0;
        tick(10);
        check("R8", {31'd0, rst_n}, 32'd1);
        check("R8", {24'd0, flags}, {24'd0, saved});
        supply_ok = 1'b1;
        tick(5);
        mon_en = 1'b1;
        tick(3);

        // firmware deselects the monitor
        wr(8'h00);
        check("R9", {24'd0, flags}, {24'd0, saved});
        supply_ok = 1'b0;
        tick(10);
        check("R9", {31'd0, rst_n}, 32'd1);
        check("R9", {24'd0, flags}, {24'd0, saved});
        supply_ok = 1'b1;
        tick(5);
        wr(8'h02);
        supply_ok = 1'b0;
        tick(3);
        check("R9", {31'd0, rst_n}, 32'd0);
        tick(5);
        rise_and_release("R9");

        // failure beats a pulse in progress
        tick(4);
        supply_ok = 1'b0;
        pin_req = 1'b1;
        tick(1);
        check("R11", {31'd0, rst_n}, 32'd0);
        tick(2);
        pin_req = 1'b0;
        tick(P + 5);
        check("R11", {31'd0, rst_n}, 32'd0);
        supply_ok = 1'b1;
        tick(H + 1);
        check("R11", {31'd0, rst_n}, 32'd0);
        tick(1);
        check("R11", {31'd0, rst_n}, 32'd1);
        check("R11", {24'd0, flags}, 32'h02);
        check("R10", {16'd0, vec}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule